// File: doc/BRIEF.md
# Single-Wire Slave Bit Transceiver

This block is the bit-level front end of a slave device on a single-wire, open-drain bus. It takes the raw bus level and passes it through a two-stage synchronizer. It measures how long each low period lasts, counting from the falling edge that the master drives. From that length it tells a data slot from a bus reset. It also returns a presence pulse after every reset by asserting an active-low pull-down enable. Byte assembly and command decoding sit in the upper layer, which gets one pulse per received bit and supplies the bit to be returned in each read slot.

There are two speed profiles: regular and overdrive. The upper layer asks for overdrive with a one-cycle request. The block holds the current speed itself, because only a long reset may drop back to regular speed. Every time constant is written in microseconds and converted to clock cycles through `CLK_PER_US`.

The receive side is a stream with no back-pressure. The master owns the timing of the bus, so a slot cannot be stalled, and the consumer must take every `rx_valid` pulse in the cycle it appears. On the transmit side, `tx_en` acts as the valid signal. It must be set, with `tx_bit`, before the master starts a read slot and held until `tx_ack` answers. `tx_ack` pulses once when a slot has consumed the bit.

Top module: `owx_bit_xcvr`

## Requirements
- R1: After reset, `pull_n` is 1, `od_active` is 0, and `rx_valid`, `tx_ack` and `reset_seen` are 0. While no slot or presence pulse is in progress, `pull_n` stays 1.
- R2: With `tx_en` = 0, a master low shorter than the sample point (30 µs regular, 3 µs overdrive) produces exactly one single-cycle `rx_valid` pulse with `rx_bit` = 1, shortly after the bus rises.
- R3: With `tx_en` = 0, a master low that is still present at the sample point but ends within the slot limit (120 µs regular, 16 µs overdrive) produces one `rx_valid` pulse with `rx_bit` = 0.
- R4: With `tx_en` = 1 and `tx_bit` = 0, the block pulls the bus low from shortly after the master's falling edge. The bus reads 0 at 15 µs (2 µs in overdrive) and has been released by 45 µs (4 µs in overdrive). `tx_ack` pulses once and `rx_valid` does not pulse.
- R5: With `tx_en` = 1 and `tx_bit` = 1, the block never pulls the bus during the slot, so the bus reads 1 at the master's sample time. `tx_ack` pulses once and `rx_valid` does not pulse.
- R6: At regular speed, a low of at least 480 µs gives one `reset_seen` pulse when the bus rises. A presence pulse then follows: the bus goes low 15–60 µs after the rise and stays low for 60–240 µs.
- R7: A one-cycle `od_set` pulse sets `od_active`. In overdrive, a low of 48 µs up to less than 480 µs is a reset that keeps `od_active` at 1 and gives a presence pulse with overdrive timing: a 2–6 µs wait and an 8–24 µs low.
- R8: In overdrive, a low of 480 µs or more clears `od_active` when `reset_seen` pulses, and the presence pulse that follows uses regular timing.
- R9: A low longer than the slot limit but shorter than the reset threshold for the current speed is ignored. It gives no `rx_valid`, no `tx_ack` and no `reset_seen`, and `od_active` does not change. Examples are 200 µs at regular speed and 30 µs in overdrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Raw bus level, asynchronous |
| pull_n | output | 1 | Active-low pull-down enable for the bus |
| od_set | input | 1 | One-cycle request to enter overdrive |
| od_active | output | 1 | Current speed, 1 = overdrive |
| rx_valid | output | 1 | One-cycle pulse for each received bit |
| rx_bit | output | 1 | Value of the received bit, valid with `rx_valid` |
| tx_en | input | 1 | Next slot is a read slot that returns `tx_bit` |
| tx_bit | input | 1 | Bit to return in the next read slot |
| tx_ack | output | 1 | One-cycle pulse when a read slot has consumed `tx_bit` |
| reset_seen | output | 1 | One-cycle pulse when a bus reset has been recognised |

## Verification
The assertions take for granted four things about the inputs:
- The master leaves the bus high between lows for longer than the synchronizer delay.
- `tx_en` and `tx_bit` are stable from before a falling edge until that slot's `tx_ack`.
- `od_set` arrives only while the bus is idle.
- The master does not start a new low while a presence pulse is running.

The stimulus follows the same rules. Every task sets `tx_en` before it lowers the bus and clears it only after the recovery gap. Each random low length is drawn from inside the range that the requirement for that case allows. A fixed gap of idle cycles follows every slot and every presence pulse.

// File: rtl/owx_pkg.sv
package owx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_PRES
  } owx_state_e;

  typedef enum logic [1:0] {
    P_OFF,
    P_WAIT,
    P_DRIVE
  } owx_pres_e;

  function automatic int us_to_cyc(input int us, input int clk_per_us);
    return us * clk_per_us;
  endfunction

endpackage

// File: rtl/owx_sync.sv
module owx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic fall
);

  logic [STAGES-1:0] sr;
  logic              q_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '1;
      q_d <= 1'b1;
    end else begin
      sr  <= {sr[STAGES-2:0], d};
      q_d <= sr[STAGES-1];
    end
  end

  assign q    = sr[STAGES-1];
  assign fall = q_d & ~sr[STAGES-1];

endmodule

// File: rtl/owx_lowtimer.sv
module owx_lowtimer #(
  parameter int CW  = 11,
  parameter int MAX = 1920
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LIM = CW'(MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear)             cnt <= '0;
    else if (en && cnt != LIM)  cnt <= cnt + 1'b1;
  end

  // R9
  tmr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);

  // R9
  tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/owx_presence.sv
module owx_presence import owx_pkg::*; #(
  parameter int CW      = 11,
  parameter int PDH_STD = 120,
  parameter int PDL_STD = 480,
  parameter int PDH_OD  = 16,
  parameter int PDL_OD  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic od,
  output logic drive,
  output logic busy
);

  owx_pres_e     phase;
  logic          od_l;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (phase)
      P_WAIT:  lim = od_l ? CW'(PDH_OD - 1) : CW'(PDH_STD - 1);
      P_DRIVE: lim = od_l ? CW'(PDL_OD - 1) : CW'(PDL_STD - 1);
      default: lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_OFF;
      cnt   <= '0;
      od_l  <= 1'b0;
    end else if (start) begin
      phase <= P_WAIT;
      cnt   <= '0;
      od_l  <= od;
    end else begin
      case (phase)
        P_WAIT:
          if (cnt == lim) begin
            phase <= P_DRIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        P_DRIVE:
          if (cnt == lim) begin
            phase <= P_OFF;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: cnt <= '0;
      endcase
    end
  end

  assign drive = (phase == P_DRIVE);
  assign busy  = (phase != P_OFF);

  // R6
  pres_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R6
  pres_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(drive));

endmodule

// File: rtl/owx_bit_xcvr.sv
module owx_bit_xcvr import owx_pkg::*; #(
  parameter int CLK_PER_US  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SAMP_STD_US = 30,
  parameter int SAMP_OD_US  = 3,
  parameter int RDRV_STD_US = 30,
  parameter int RDRV_OD_US  = 2,
  parameter int SLOT_STD_US = 120,
  parameter int SLOT_OD_US  = 16,
  parameter int RST_STD_US  = 480,
  parameter int RST_OD_US   = 48,
  parameter int PDH_STD_US  = 30,
  parameter int PDH_OD_US   = 4,
  parameter int PDL_STD_US  = 120,
  parameter int PDL_OD_US   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_i,
  output logic pull_n,
  input  logic od_set,
  output logic od_active,
  output logic rx_valid,
  output logic rx_bit,
  input  logic tx_en,
  input  logic tx_bit,
  output logic tx_ack,
  output logic reset_seen
);

  localparam int CNT_MAX = us_to_cyc(RST_STD_US, CLK_PER_US);
  localparam int CW      = $clog2(CNT_MAX + 1);

  localparam logic [CW-1:0] SAMP_STD = CW'(us_to_cyc(SAMP_STD_US, CLK_PER_US));
  localparam logic [CW-1:0] SAMP_OD  = CW'(us_to_cyc(SAMP_OD_US, CLK_PER_US));
  localparam logic [CW-1:0] RDRV_STD = CW'(us_to_cyc(RDRV_STD_US, CLK_PER_US));
  localparam logic [CW-1:0] RDRV_OD  = CW'(us_to_cyc(RDRV_OD_US, CLK_PER_US));
  localparam logic [CW-1:0] SLOT_STD = CW'(us_to_cyc(SLOT_STD_US, CLK_PER_US));
  localparam logic [CW-1:0] SLOT_OD  = CW'(us_to_cyc(SLOT_OD_US, CLK_PER_US));
  localparam logic [CW-1:0] RST_STD  = CW'(CNT_MAX);
  localparam logic [CW-1:0] RST_OD   = CW'(us_to_cyc(RST_OD_US, CLK_PER_US));

  owx_state_e    state;
  logic          bus_s, bus_fall;
  logic [CW-1:0] cnt;
  logic          tmr_clr, tmr_en;
  logic          read_q, rbit_q, samp_q, od_q;
  logic          pres_start, pres_drive, pres_busy;
  logic          rd_drive;
  logic [CW-1:0] samp_c, rdrv_c, slot_c, rst_c;

  owx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (bus_i),
    .q    (bus_s),
    .fall (bus_fall)
  );

  assign tmr_clr = (state != ST_LOW);
  assign tmr_en  = (state == ST_LOW) && !bus_s;

  owx_lowtimer #(.CW(CW), .MAX(CNT_MAX)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(tmr_clr),
    .en   (tmr_en),
    .cnt  (cnt)
  );

  owx_presence #(
    .CW     (CW),
    .PDH_STD(us_to_cyc(PDH_STD_US, CLK_PER_US)),
    .PDL_STD(us_to_cyc(PDL_STD_US, CLK_PER_US)),
    .PDH_OD (us_to_cyc(PDH_OD_US, CLK_PER_US)),
    .PDL_OD (us_to_cyc(PDL_OD_US, CLK_PER_US))
  ) u_pres (
    .clk  (clk),
    .rst_n(rst_n),
    .start(pres_start),
    .od   (od_q),
    .drive(pres_drive),
    .busy (pres_busy)
  );

  always_comb begin
    samp_c = od_q ? SAMP_OD : SAMP_STD;
    rdrv_c = od_q ? RDRV_OD : RDRV_STD;
    slot_c = od_q ? SLOT_OD : SLOT_STD;
    rst_c  = od_q ? RST_OD  : RST_STD;
  end

  assign rd_drive  = (state == ST_LOW) && read_q && !rbit_q && (cnt < rdrv_c);
  assign pull_n    = ~(rd_drive | pres_drive);
  assign od_active = od_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      read_q     <= 1'b0;
      rbit_q     <= 1'b0;
      samp_q     <= 1'b1;
      od_q       <= 1'b0;
      pres_start <= 1'b0;
      rx_valid   <= 1'b0;
      rx_bit     <= 1'b0;
      tx_ack     <= 1'b0;
      reset_seen <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      tx_ack     <= 1'b0;
      reset_seen <= 1'b0;
      pres_start <= 1'b0;
      if (od_set) od_q <= 1'b1;
      case (state)
        ST_IDLE:
          if (bus_fall) begin
            state  <= ST_LOW;
            read_q <= tx_en;
            rbit_q <= tx_bit;
            samp_q <= 1'b1;
          end
        ST_LOW:
          if (bus_s) begin
            if (cnt <= slot_c) begin
              if (read_q) begin
                tx_ack <= 1'b1;
              end else begin
                rx_valid <= 1'b1;
                rx_bit   <= samp_q;
              end
            end
            if (cnt >= rst_c) begin
              reset_seen <= 1'b1;
              pres_start <= 1'b1;
              state      <= ST_PRES;
              if (cnt >= RST_STD) od_q <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else if (cnt == samp_c) begin
            samp_q <= 1'b0;
          end
        ST_PRES:
          if (!pres_start && !pres_busy && bus_s) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> pull_n);

  // R4
  drive_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pull_n |-> (pres_busy || (state == ST_LOW && read_q && !rbit_q)));

  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9
  rx_not_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !reset_seen);

  // R6
  reset_pres_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |=> pres_busy);

  // R8
  od_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_q) |-> reset_seen);

  // R7
  od_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od_set |=> (od_q || reset_seen));

endmodule

// File: tb/test_owx_bit_xcvr.sv
module test_owx_bit_xcvr;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic od_set = 1'b0;
  logic tx_en = 1'b0;
  logic tx_bit = 1'b0;
  logic bus;
  logic pull_n, od_active, rx_valid, rx_bit, tx_ack, reset_seen;

  int n_chk = 0, n_err = 0;
  int n_rx = 0, n_ack = 0, n_rst = 0;
  bit last_rx = 1'b0;
  bit od_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus = !(m_low || !pull_n);

  owx_bit_xcvr #(.CLK_PER_US(CPU)) i_owx_bit_xcvr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_i     (bus),
    .pull_n    (pull_n),
    .od_set    (od_set),
    .od_active (od_active),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .tx_en     (tx_en),
    .tx_bit    (tx_bit),
    .tx_ack    (tx_ack),
    .reset_seen(reset_seen)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      n_rx++;
      last_rx = rx_bit;
    end
    if (tx_ack) n_ack++;
    if (reset_seen) n_rst++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_win(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic int wr_len(input bit b, input bit od);
    if (b) return od ? $urandom_range(8, 4) : $urandom_range(60, 4);
    return od ? $urandom_range(56, 24) : $urandom_range(440, 240);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_slot(input bit b);
    int len = wr_len(b, od_m);
    int r0  = n_rx;
    @(negedge clk) m_low = 1'b1;
    idle(len);
    m_low = 1'b0;
    idle(20);
    check(n_rx == r0 + 1, b ? "R2 rx count" : "R3 rx count", n_rx - r0, 1);
    check(last_rx == b, b ? "R2 rx bit" : "R3 rx bit", int'(last_rx), int'(b));
  endtask

  task automatic read_slot(input bit b);
    int  samp = od_m ? 2*CPU  : 15*CPU;
    int  rel  = od_m ? 4*CPU  : 45*CPU;
    int  len  = od_m ? 6*CPU  : 60*CPU;
    int  a0   = n_ack;
    int  r0   = n_rx;
    bit  seen = 1'b1;
    bit  late = 1'b0;
    tx_en  = 1'b1;
    tx_bit = b;
    @(negedge clk) m_low = 1'b1;
    for (int c = 1; c <= len; c++) begin
      @(negedge clk);
      if (c == CPU) m_low = 1'b0;
      if (c == samp) seen = bus;
      if (c == rel) late = !bus;
    end
    idle(10);
    tx_en = 1'b0;
    check(seen == b, b ? "R5 read value" : "R4 read value", int'(seen), int'(b));
    check(!late, b ? "R5 released" : "R4 released", int'(late), 0);
    check(n_ack == a0 + 1, b ? "R5 ack" : "R4 ack", n_ack - a0, 1);
    check(n_rx == r0, b ? "R5 no rx" : "R4 no rx", n_rx - r0, 0);
  endtask

  task automatic do_reset(input int low_cyc, input bit exp_od, input string req);
    int r0 = n_rst;
    int th = 0;
    int tl = 0;
    @(negedge clk) m_low = 1'b1;
    idle(low_cyc);
    m_low = 1'b0;
    while (pull_n && th < 4000) begin
      @(negedge clk);
      th++;
    end
    while (!pull_n && tl < 4000) begin
      @(negedge clk);
      tl++;
    end
    idle(20);
    check(n_rst == r0 + 1, req, n_rst - r0, 1);
    check(od_active == exp_od, req, int'(od_active), int'(exp_od));
    if (exp_od) begin
      check(in_win(th, 2*CPU, 6*CPU), req, th, 4*CPU);
      check(in_win(tl, 8*CPU, 24*CPU), req, tl, 16*CPU);
    end else begin
      check(in_win(th, 15*CPU, 60*CPU), req, th, 30*CPU);
      check(in_win(tl, 60*CPU, 240*CPU), req, tl, 120*CPU);
    end
    od_m = exp_od;
  endtask

  task automatic ignored_low(input int low_cyc);
    int r0 = n_rx;
    int a0 = n_ack;
    int s0 = n_rst;
    @(negedge clk) m_low = 1'b1;
    idle(low_cyc);
    m_low = 1'b0;
    idle(40);
    check(n_rx == r0, "R9 no rx", n_rx - r0, 0);
    check(n_ack == a0, "R9 no ack", n_ack - a0, 0);
    check(n_rst == s0, "R9 no reset", n_rst - s0, 0);
    check(od_active == od_m, "R9 od kept", int'(od_active), int'(od_m));
    check(pull_n == 1'b1, "R9 no presence", int'(pull_n), 1);
  endtask

  task automatic enter_od();
    @(negedge clk) od_set = 1'b1;
    @(negedge clk) od_set = 1'b0;
    idle(2);
    od_m = 1'b1;
    check(od_active == 1'b1, "R7 od set", int'(od_active), 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state
    check(pull_n == 1'b1, "R1 pull_n", int'(pull_n), 1);
    check(od_active == 1'b0, "R1 od", int'(od_active), 0);
    check(n_rx + n_ack + n_rst == 0, "R1 pulses", n_rx + n_ack + n_rst, 0);

    // regular-speed directed cases
    write_slot(1'b1);
    write_slot(1'b0);
    read_slot(1'b0);
    read_slot(1'b1);
    do_reset(500*CPU, 1'b0, "R6 regular reset");
    ignored_low(200*CPU);

    // overdrive directed cases
    enter_od();
    write_slot(1'b1);
    write_slot(1'b0);
    read_slot(1'b0);
    read_slot(1'b1);
    do_reset(60*CPU, 1'b1, "R7 short reset keeps od");
    ignored_low(30*CPU);
    do_reset(500*CPU, 1'b0, "R8 long reset clears od");

    // random mix
    for (int i = 0; i < 50; i++) begin
      int op = $urandom_range(9, 0);
      if (op < 5)      write_slot(1'($urandom_range(1, 0)));
      else if (op < 9) read_slot(1'($urandom_range(1, 0)));
      else if (od_m)   do_reset(500*CPU, 1'b0, "R8 random long reset");
      else             enter_od();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule